// File: doc/BRIEF.md
# Register window rotation controller

This block owns a windowed register file of `NAREG` physical 32-bit registers, of which sixteen logical registers are visible at any moment. A window base, counted in groups of four registers, selects the visible slice, and a start mask with one bit per group records which groups begin a live call frame. Both the base and all register mapping wrap modulo the physical file size, so a frame near the top of the file spills over onto the bottom.

One operation is accepted per cycle on the `op*` inputs: call entry, windowed return, signed rotate, restore from the saved base, absolute base load, the stack-pointer move check and the pre-access overflow check. The block decides legality and classifies spill and fill events as 4-, 8- or 12-register events. It commits the register write, the base update, the start mask, the saved base, the exception-mode flag and the exception PC together in one clock edge, and it reports the exception code or the return address one cycle after the operation. A configuration strobe loads the mode bits, the call increment and the start mask. A plain logical write port and a combinational logical read port give access to the file through the current window.

Top module: `regwin_rotator`

## Requirements
- R1: After reset the base is 0, the start mask is 1 (group 0 live), exception mode and the saved base are 0, window-overflow-enable is 1, no exception or return is reported, and every register reads 0.
- R2: Logical register i, for the write port and the read port, addresses physical register (base*4 + i) mod NAREG.
- R3: Call entry (opCode 0) is illegal, reported as code 1, when opS > 3, when overflow-enable is 0 or when exception mode is 1; an illegal entry leaves base, mask and registers unchanged.
- R4: A legal entry writes a[opS] - opImm*8 into logical register CALLINC*4 + opS of the old window, adds CALLINC to the base and sets the mask bit of the new base. If the logical write port hits the same physical register in that cycle, the entry's value wins; a write to a different register still lands.
- R5: The overflow check (opCode 6) acts only when overflow-enable is 1 and exception mode is 0. It looks for the nearest set mask bit at base+n for n = 1..opWin and does nothing when none is found.
- R6: On a hit at distance n the base moves to m = base+n, the old base is saved, exception mode is set and the exception PC takes opPc. The code is 3 (4-register) when bit m+1 is set, else 4 (8-register) when bit m+2 is set, else 5 (12-register).
- R7: Windowed return (opCode 1) takes n = a0[31:30] and m = 1, 2 or 3 as the nearest set bit at base-1, base-2, base-3 (0 if none). It is illegal, code 1, when n = 0, when m is nonzero and differs from n, or when the mode condition of R3 fails; the base is then unchanged.
- R8: A legal return moves the base to base-n. If the mask bit of the new base is set, the old base's bit is cleared and retValid pulses with retPc = {opPc[31:30], a0[29:0]}.
- R9: If that bit is clear, the return is an underflow: the mask is kept, the old base is saved, exception mode is set, the exception PC takes opPc, and the code is 6, 7 or 8 for n = 1, 2 or 3.
- R10: The stack-pointer move check (opCode 5) reports code 2 when the mask bits at base-1, base-2 and base-3 are all clear, and otherwise reports nothing; it never moves the base.
- R11: Rotate (opCode 2) adds the sign-extended 4-bit opRot to the base modulo the group count; restore (opCode 3) loads the base from the saved base; absolute load (opCode 4) loads opBase.
- R12: All effects of an operation are visible after the next rising edge; excValid (code nonzero) and retValid are registered, last one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe |
| opCode | input | 3 | Operation select (0 entry, 1 return, 2 rotate, 3 restore, 4 absolute base, 5 stack-pointer check, 6 overflow check) |
| opS | input | 4 | Entry stack register index |
| opImm | input | 12 | Entry frame size in 8-byte units |
| opWin | input | 2 | Overflow check reach, 0..3 |
| opRot | input | 4 | Signed rotate amount |
| opBase | input | log2(NAREG/4) | Absolute base value |
| opPc | input | 32 | PC of the operation |
| wrEn | input | 1 | Logical register write strobe |
| wrIdx | input | 4 | Logical register written |
| wrData | input | 32 | Write data |
| rdIdx | input | 4 | Logical register read |
| rdData | output | 32 | Read data through the current window |
| cfgEn | input | 1 | Loads mode bits, call increment and start mask; wins over an operation's updates to them |
| cfgWoe | input | 1 | Overflow-enable value |
| cfgExcm | input | 1 | Exception-mode value |
| cfgCallinc | input | 2 | Call increment value |
| cfgStart | input | NAREG/4 | Start mask value |
| winBase | output | log2(NAREG/4) | Current window base |
| winStart | output | NAREG/4 | Current start mask |
| stExcm | output | 1 | Exception mode flag |
| stOwb | output | log2(NAREG/4) | Saved old base |
| epc | output | 32 | Exception PC |
| excValid | output | 1 | Exception reported this cycle |
| excCode | output | 4 | Exception code (0 none) |
| retValid | output | 1 | Completed return this cycle |
| retPc | output | 32 | Return address |

## Verification
The operation that writes the file, call entry, can fall in the same cycle as a write on the logical port. The bench provokes both the case where the two resolve to the same physical register and the case where they do not. It then rotates the window and reads back through the new mapping: the entry's computed value must win the shared register, and the port value must survive in its own register. The overflow and underflow variants and the wrap of the mapping across the top of the file are judged the same way, by values read through the ports after each step.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [2:0] {
    OP_ENTRY   = 3'd0,
    OP_RETW    = 3'd1,
    OP_ROTW    = 3'd2,
    OP_RESTORE = 3'd3,
    OP_SETBASE = 3'd4,
    OP_MOVSP   = 3'd5,
    OP_WCHECK  = 3'd6
  } rwOp_e;

  typedef enum logic [3:0] {
    EX_NONE    = 4'd0,
    EX_ILLEGAL = 4'd1,
    EX_ALLOCA  = 4'd2,
    EX_OVF4    = 4'd3,
    EX_OVF8    = 4'd4,
    EX_OVF12   = 4'd5,
    EX_UNF4    = 4'd6,
    EX_UNF8    = 4'd7,
    EX_UNF12   = 4'd8
  } rwExc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   baseLoad;
    logic   startSetNew;
    logic   startClrOld;
    logic   owbLoad;
    logic   excmSet;
    logic   epcLoad;
    logic   rfWrite;
    logic   retLoad;
    rwExc_e exc;
  } rwCtl_t;

endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NGRP = 16,
  parameter int GW   = 4,
  parameter int XW   = 32
) (
  input  logic            opValid,
  input  logic [2:0]      opCode,
  input  logic [3:0]      opS,
  input  logic [11:0]     opImm,
  input  logic [1:0]      opWin,
  input  logic [3:0]      opRot,
  input  logic [GW-1:0]   opBase,
  input  logic [XW-1:0]   opPc,
  input  logic [GW-1:0]   base,
  input  logic [NGRP-1:0] start,
  input  logic            woe,
  input  logic            excm,
  input  logic [1:0]      callinc,
  input  logic [GW-1:0]   owb,
  input  logic [XW-1:0]   regS,
  input  logic [XW-1:0]   regA0,
  output rwCtl_t          ctl,
  output logic [GW-1:0]   baseNext,
  output logic [3:0]      rfIdx,
  output logic [XW-1:0]   rfData,
  output logic [XW-1:0]   retPc
);

  rwOp_e         op;
  logic          winOk;
  logic [GW-1:0] up1, up2, up3, dn1, dn2, dn3;
  logic [1:0]    nHit, mHit, retN;
  logic [GW-1:0] mPos;

  assign op    = rwOp_e'(opCode);
  assign winOk = woe & ~excm;
  assign up1   = base + GW'(1);
  assign up2   = base + GW'(2);
  assign up3   = base + GW'(3);
  assign dn1   = base - GW'(1);
  assign dn2   = base - GW'(2);
  assign dn3   = base - GW'(3);
  assign retN  = regA0[XW-1:XW-2];

  // nearest live frame above (overflow search) and below (return check)
  always_comb begin
    nHit = 2'd0;
    if (opWin >= 2'd1 && start[up1])      nHit = 2'd1;
    else if (opWin >= 2'd2 && start[up2]) nHit = 2'd2;
    else if (opWin == 2'd3 && start[up3]) nHit = 2'd3;
    mHit = 2'd0;
    if (start[dn1])      mHit = 2'd1;
    else if (start[dn2]) mHit = 2'd2;
    else if (start[dn3]) mHit = 2'd3;
    mPos = base + GW'(nHit);
  end

  always_comb begin
    ctl      = '0;
    ctl.exc  = EX_NONE;
    baseNext = base;
    rfIdx    = '0;
    rfData   = '0;
    retPc    = '0;
    if (opValid) begin
      unique case (op)
        OP_ENTRY: begin
          if (opS > 4'd3 || !winOk) begin
            ctl.exc = EX_ILLEGAL;
          end else begin
            ctl.rfWrite     = 1'b1;
            rfIdx           = {callinc, opS[1:0]};
            rfData          = regS - XW'({opImm, 3'b000});
            ctl.baseLoad    = 1'b1;
            baseNext        = base + GW'(callinc);
            ctl.startSetNew = 1'b1;
          end
        end
        OP_WCHECK: begin
          if (winOk && nHit != 2'd0) begin
            ctl.baseLoad = 1'b1;
            baseNext     = mPos;
            ctl.owbLoad  = 1'b1;
            ctl.excmSet  = 1'b1;
            ctl.epcLoad  = 1'b1;
            if (start[mPos + GW'(1)])      ctl.exc = EX_OVF4;
            else if (start[mPos + GW'(2)]) ctl.exc = EX_OVF8;
            else                           ctl.exc = EX_OVF12;
          end
        end
        OP_RETW: begin
          if (retN == 2'd0 || (mHit != 2'd0 && mHit != retN) || !winOk) begin
            ctl.exc = EX_ILLEGAL;
          end else begin
            ctl.baseLoad = 1'b1;
            baseNext     = base - GW'(retN);
            if (start[baseNext]) begin
              ctl.startClrOld = 1'b1;
              ctl.retLoad     = 1'b1;
              retPc           = {opPc[XW-1:XW-2], regA0[XW-3:0]};
            end else begin
              ctl.owbLoad = 1'b1;
              ctl.excmSet = 1'b1;
              ctl.epcLoad = 1'b1;
              case (retN)
                2'd1:    ctl.exc = EX_UNF4;
                2'd2:    ctl.exc = EX_UNF8;
                default: ctl.exc = EX_UNF12;
              endcase
            end
          end
        end
        OP_ROTW: begin
          ctl.baseLoad = 1'b1;
          baseNext     = base + GW'($signed(opRot));
        end
        OP_RESTORE: begin
          ctl.baseLoad = 1'b1;
          baseNext     = owb;
        end
        OP_SETBASE: begin
          ctl.baseLoad = 1'b1;
          baseNext     = opBase;
        end
        OP_MOVSP: begin
          if (!start[dn1] && !start[dn2] && !start[dn3]) ctl.exc = EX_ALLOCA;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/regwin_dp.sv
module regwin_dp
  import regwin_pkg::*;
#(
  parameter int NAREG = 64,
  parameter int NGRP  = 16,
  parameter int GW    = 4,
  parameter int PW    = 6,
  parameter int XW    = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  rwCtl_t          ctl,
  input  logic [GW-1:0]   baseNext,
  input  logic [3:0]      rfIdx,
  input  logic [XW-1:0]   rfData,
  input  logic [XW-1:0]   retPcIn,
  input  logic [3:0]      opS,
  input  logic [XW-1:0]   opPc,
  input  logic            wrEn,
  input  logic [3:0]      wrIdx,
  input  logic [XW-1:0]   wrData,
  input  logic [3:0]      rdIdx,
  output logic [XW-1:0]   rdData,
  input  logic            cfgEn,
  input  logic            cfgWoe,
  input  logic            cfgExcm,
  input  logic [1:0]      cfgCallinc,
  input  logic [NGRP-1:0] cfgStart,
  output logic [XW-1:0]   regS,
  output logic [XW-1:0]   regA0,
  output logic [GW-1:0]   base,
  output logic [NGRP-1:0] start,
  output logic            woe,
  output logic            excm,
  output logic [1:0]      callinc,
  output logic [GW-1:0]   owb,
  output logic [XW-1:0]   epc,
  output logic            excValid,
  output logic [3:0]      excCode,
  output logic            retValid,
  output logic [XW-1:0]   retPc
);

  logic [XW-1:0]   rf [NAREG];
  logic [NGRP-1:0] setMask, clrMask;

  function automatic logic [PW-1:0] physOf(input logic [GW-1:0] b, input logic [3:0] li);
    return {b, 2'b00} + PW'(li);
  endfunction

  assign rdData  = rf[physOf(base, rdIdx)];
  assign regS    = rf[physOf(base, {2'b00, opS[1:0]})];
  assign regA0   = rf[physOf(base, 4'd0)];
  assign setMask = ctl.startSetNew ? (NGRP'(1) << baseNext) : '0;
  assign clrMask = ctl.startClrOld ? (NGRP'(1) << base) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NAREG; i++) rf[i] <= '0;
    end else begin
      if (wrEn)        rf[physOf(base, wrIdx)] <= wrData;
      if (ctl.rfWrite) rf[physOf(base, rfIdx)] <= rfData;  // op write wins
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base     <= '0;
      start    <= NGRP'(1);
      woe      <= 1'b1;
      excm     <= 1'b0;
      callinc  <= 2'd0;
      owb      <= '0;
      epc      <= '0;
      excValid <= 1'b0;
      excCode  <= 4'd0;
      retValid <= 1'b0;
      retPc    <= '0;
    end else begin
      if (ctl.baseLoad) base <= baseNext;
      if (ctl.owbLoad)  owb  <= base;
      if (ctl.epcLoad)  epc  <= opPc;
      if (cfgEn) begin
        start   <= cfgStart;
        woe     <= cfgWoe;
        excm    <= cfgExcm;
        callinc <= cfgCallinc;
      end else begin
        start <= (start | setMask) & ~clrMask;
        if (ctl.excmSet) excm <= 1'b1;
      end
      excValid <= (ctl.exc != EX_NONE);
      excCode  <= ctl.exc;
      retValid <= ctl.retLoad;
      if (ctl.retLoad) retPc <= retPcIn;
    end
  end

endmodule

// File: rtl/regwin_rotator.sv
module regwin_rotator
  import regwin_pkg::*;
#(
  parameter int NAREG = 64,
  localparam int NGRP = NAREG / 4,
  localparam int GW   = $clog2(NGRP),
  localparam int PW   = $clog2(NAREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [2:0]      opCode,
  input  logic [3:0]      opS,
  input  logic [11:0]     opImm,
  input  logic [1:0]      opWin,
  input  logic [3:0]      opRot,
  input  logic [GW-1:0]   opBase,
  input  logic [31:0]     opPc,
  input  logic            wrEn,
  input  logic [3:0]      wrIdx,
  input  logic [31:0]     wrData,
  input  logic [3:0]      rdIdx,
  output logic [31:0]     rdData,
  input  logic            cfgEn,
  input  logic            cfgWoe,
  input  logic            cfgExcm,
  input  logic [1:0]      cfgCallinc,
  input  logic [NGRP-1:0] cfgStart,
  output logic [GW-1:0]   winBase,
  output logic [NGRP-1:0] winStart,
  output logic            stExcm,
  output logic [GW-1:0]   stOwb,
  output logic [31:0]     epc,
  output logic            excValid,
  output logic [3:0]      excCode,
  output logic            retValid,
  output logic [31:0]     retPc
);

  rwCtl_t        ctl;
  logic [GW-1:0] baseNext;
  logic [3:0]    rfIdx;
  logic [31:0]   rfData, retPcNext, regS, regA0;
  logic          woe;
  logic [1:0]    callinc;

  regwin_ctrl #(.NGRP(NGRP), .GW(GW), .XW(32)) u_ctrl (
    .opValid(opValid), .opCode(opCode), .opS(opS), .opImm(opImm),
    .opWin(opWin), .opRot(opRot), .opBase(opBase), .opPc(opPc),
    .base(winBase), .start(winStart), .woe(woe), .excm(stExcm),
    .callinc(callinc), .owb(stOwb), .regS(regS), .regA0(regA0),
    .ctl(ctl), .baseNext(baseNext), .rfIdx(rfIdx), .rfData(rfData),
    .retPc(retPcNext)
  );

  regwin_dp #(.NAREG(NAREG), .NGRP(NGRP), .GW(GW), .PW(PW), .XW(32)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .baseNext(baseNext),
    .rfIdx(rfIdx), .rfData(rfData), .retPcIn(retPcNext),
    .opS(opS), .opPc(opPc), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .cfgEn(cfgEn), .cfgWoe(cfgWoe),
    .cfgExcm(cfgExcm), .cfgCallinc(cfgCallinc), .cfgStart(cfgStart),
    .regS(regS), .regA0(regA0), .base(winBase), .start(winStart),
    .woe(woe), .excm(stExcm), .callinc(callinc), .owb(stOwb), .epc(epc),
    .excValid(excValid), .excCode(excCode), .retValid(retValid),
    .retPc(retPc)
  );

endmodule

// File: rtl/regwin_rotator_chk.sv
module regwin_rotator_chk #(
  parameter int NAREG = 64,
  localparam int NGRP = NAREG / 4,
  localparam int GW   = $clog2(NGRP)
) (
  input logic            clk,
  input logic            rstN,
  input logic            opValid,
  input logic [2:0]      opCode,
  input logic [3:0]      opS,
  input logic [3:0]      opRot,
  input logic            cfgEn,
  input logic [GW-1:0]   winBase,
  input logic [NGRP-1:0] winStart,
  input logic            stExcm,
  input logic            excValid,
  input logic [3:0]      excCode,
  input logic            retValid
);

  // R3: out-of-range stack index is refused and the window stays put
  p_entry_illegal_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd0 && opS > 4'd3 && !cfgEn)
      |=> (excValid && excCode == 4'd1 && $stable(winBase)));

  // R4: after an entry either it was refused or the new base is live
  p_entry_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd0 && !cfgEn) |=> (excValid || winStart[winBase]));

  // R6: exception mode is only cleared by configuration
  p_excm_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stExcm && !cfgEn) |=> stExcm);

  // R9: every spill or fill event is reported with exception mode set
  p_win_exc_excm_r9: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excCode >= 4'd3 && !$past(cfgEn)) |-> stExcm);

  // R10: the stack-pointer check never moves the window
  p_movsp_still_r10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd5) |=> ($stable(winBase) && !retValid));

  // R11: rotate adds the signed amount modulo the group count
  p_rotw_r11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd2) |=>
      (winBase == $past(winBase) + GW'($signed($past(opRot)))));

  // R12: a return and an exception are never reported together
  p_ret_exc_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({excValid, retValid}));

endmodule

bind regwin_rotator regwin_rotator_chk #(.NAREG(NAREG)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opS(opS),
  .opRot(opRot), .cfgEn(cfgEn), .winBase(winBase), .winStart(winStart),
  .stExcm(stExcm), .excValid(excValid), .excCode(excCode),
  .retValid(retValid)
);

// File: tb/regwin_rotator_bench.sv
module regwin_rotator_bench;

  localparam int NAREG = 64;
  localparam int NGRP  = NAREG / 4;
  localparam int GW    = $clog2(NGRP);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            opValid = 1'b0;
  logic [2:0]      opCode = '0;
  logic [3:0]      opS = '0;
  logic [11:0]     opImm = '0;
  logic [1:0]      opWin = '0;
  logic [3:0]      opRot = '0;
  logic [GW-1:0]   opBase = '0;
  logic [31:0]     opPc = '0;
  logic            wrEn = 1'b0;
  logic [3:0]      wrIdx = '0;
  logic [31:0]     wrData = '0;
  logic [3:0]      rdIdx = '0;
  logic [31:0]     rdData;
  logic            cfgEn = 1'b0;
  logic            cfgWoe = 1'b0;
  logic            cfgExcm = 1'b0;
  logic [1:0]      cfgCallinc = '0;
  logic [NGRP-1:0] cfgStart = '0;
  logic [GW-1:0]   winBase;
  logic [NGRP-1:0] winStart;
  logic            stExcm;
  logic [GW-1:0]   stOwb;
  logic [31:0]     epc;
  logic            excValid;
  logic [3:0]      excCode;
  logic            retValid;
  logic [31:0]     retPc;

  regwin_rotator #(.NAREG(NAREG)) u_regwin_rotator (.*);

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    string       req;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;

  localparam int S_BASE = 0, S_START = 1, S_EXCM = 2, S_OWB = 3, S_EPC = 4,
                 S_EV = 5, S_CODE = 6, S_RV = 7, S_RPC = 8, S_RD = 9;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      S_BASE:  return 32'(winBase);
      S_START: return 32'(winStart);
      S_EXCM:  return 32'(stExcm);
      S_OWB:   return 32'(stOwb);
      S_EPC:   return epc;
      S_EV:    return 32'(excValid);
      S_CODE:  return 32'(excCode);
      S_RV:    return 32'(retValid);
      S_RPC:   return retPc;
      default: return rdData;
    endcase
  endfunction

  // monitor: compares due items away from the clock edge
  always @(negedge clk) begin
    #2;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = observe(it.sel);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  // expectation for the result of the operation now being driven
  task automatic expectOp(string req, int sel, logic [31:0] exp);
    item_t it;
    it.due = cyc + 1; it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  // expectation on the state right now
  task automatic expectNow(string req, int sel, logic [31:0] exp);
    item_t it;
    it.due = cyc; it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fire();
    step();
    opValid = 1'b0;
    wrEn    = 1'b0;
    cfgEn   = 1'b0;
  endtask

  task automatic setOp(logic [2:0] code);
    opValid = 1'b1;
    opCode  = code;
  endtask

  task automatic cfg(logic woe, logic excm, logic [1:0] cinc, logic [NGRP-1:0] st);
    cfgEn = 1'b1; cfgWoe = woe; cfgExcm = excm; cfgCallinc = cinc; cfgStart = st;
    fire();
  endtask

  task automatic setBase(logic [GW-1:0] b);
    setOp(3'd4); opBase = b;
    fire();
  endtask

  task automatic writeReg(logic [3:0] idx, logic [31:0] d);
    wrEn = 1'b1; wrIdx = idx; wrData = d;
    fire();
  endtask

  task automatic readReg(string req, logic [3:0] idx, logic [31:0] exp);
    rdIdx = idx;
    expectNow(req, S_RD, exp);
    step();
  endtask

  task automatic retw(logic [31:0] pc);
    setOp(3'd1); opPc = pc;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectNow("R1", S_BASE, 0);
    expectNow("R1", S_START, 32'h1);
    expectNow("R1", S_EXCM, 0);
    expectNow("R1", S_OWB, 0);
    expectNow("R1", S_EV, 0);
    expectNow("R1", S_RV, 0);
    readReg("R1", 4'd3, 0);

    cfg(1'b1, 1'b0, 2'd1, 16'h0001);

    // R2 wrap: base 15, logical 5 -> physical 1
    setBase(4'd15);
    expectNow("R11", S_BASE, 15);
    writeReg(4'd5, 32'hA5A5_0001);
    setBase(4'd0);
    readReg("R2", 4'd1, 32'hA5A5_0001);
    readReg("R2", 4'd5, 32'h0);

    // R4 legal entry with a port write to another register
    writeReg(4'd1, 32'h0000_1000);
    setOp(3'd0); opS = 4'd1; opImm = 12'd2;
    wrEn = 1'b1; wrIdx = 4'd6; wrData = 32'h0000_0066;
    expectOp("R4", S_BASE, 1);
    expectOp("R4", S_START, 32'h0003);
    expectOp("R4", S_EV, 0);
    fire();
    readReg("R4", 4'd1, 32'h0000_0FF0);
    readReg("R4", 4'd2, 32'h0000_0066);

    // R4 entry and port write to the same physical register
    writeReg(4'd0, 32'h0000_0200);
    setOp(3'd0); opS = 4'd0; opImm = 12'd1;
    wrEn = 1'b1; wrIdx = 4'd4; wrData = 32'hDEAD_BEEF;
    expectOp("R4", S_START, 32'h0007);
    fire();
    readReg("R4", 4'd0, 32'h0000_01F8);

    // R3 illegal entries
    setOp(3'd0); opS = 4'd4;
    expectOp("R3", S_CODE, 1);
    expectOp("R3", S_BASE, 2);
    fire();
    cfg(1'b1, 1'b1, 2'd1, 16'h0007);
    setOp(3'd0); opS = 4'd0;
    expectOp("R3", S_CODE, 1);
    expectOp("R3", S_START, 32'h0007);
    fire();
    cfg(1'b0, 1'b0, 2'd1, 16'h0007);
    setOp(3'd0); opS = 4'd0;
    expectOp("R3", S_CODE, 1);
    expectOp("R3", S_BASE, 2);
    fire();

    // R6 overflow-4
    cfg(1'b1, 1'b0, 2'd0, 16'h000D);
    setBase(4'd0);
    setOp(3'd6); opWin = 2'd3; opPc = 32'h1234_5678;
    expectOp("R6", S_CODE, 3);
    expectOp("R6", S_BASE, 2);
    expectOp("R6", S_OWB, 0);
    expectOp("R6", S_EXCM, 1);
    expectOp("R6", S_EPC, 32'h1234_5678);
    fire();
    // R11 restore from saved base
    setOp(3'd3);
    expectOp("R11", S_BASE, 0);
    expectOp("R12", S_EV, 0);
    fire();

    // R6 overflow-8 across the wrap
    cfg(1'b1, 1'b0, 2'd0, 16'hC002);
    setBase(4'd14);
    setOp(3'd6); opWin = 2'd2; opPc = 32'h0000_0100;
    expectOp("R6", S_CODE, 4);
    expectOp("R6", S_BASE, 15);
    expectOp("R6", S_OWB, 14);
    fire();

    // R6 overflow-12
    cfg(1'b1, 1'b0, 2'd0, 16'h0028);
    setBase(4'd3);
    setOp(3'd6); opWin = 2'd3;
    expectOp("R6", S_CODE, 5);
    expectOp("R6", S_BASE, 5);
    expectOp("R6", S_OWB, 3);
    fire();

    // R5 nothing within reach, and gated by exception mode
    cfg(1'b1, 1'b0, 2'd0, 16'h0009);
    setBase(4'd0);
    setOp(3'd6); opWin = 2'd2;
    expectOp("R5", S_EV, 0);
    expectOp("R5", S_BASE, 0);
    expectOp("R5", S_EXCM, 0);
    fire();
    cfg(1'b1, 1'b1, 2'd0, 16'h000D);
    setOp(3'd6); opWin = 2'd3;
    expectOp("R5", S_EV, 0);
    expectOp("R5", S_BASE, 0);
    fire();

    // R8 legal return
    cfg(1'b1, 1'b0, 2'd0, 16'h0005);
    setBase(4'd2);
    writeReg(4'd0, 32'h8000_0123);
    retw(32'h4ABC_0000);
    expectOp("R8", S_RV, 1);
    expectOp("R8", S_RPC, 32'h4000_0123);
    expectOp("R8", S_EV, 0);
    expectOp("R8", S_BASE, 0);
    expectOp("R8", S_START, 32'h0001);
    fire();
    expectOp("R12", S_RV, 0);
    step();

    // R9 underflow variants
    cfg(1'b1, 1'b0, 2'd0, 16'h0020);
    setBase(4'd5);
    writeReg(4'd0, 32'h4000_0010);
    retw(32'h9000_0000);
    expectOp("R9", S_CODE, 6);
    expectOp("R9", S_BASE, 4);
    expectOp("R9", S_OWB, 5);
    expectOp("R9", S_EXCM, 1);
    expectOp("R9", S_EPC, 32'h9000_0000);
    expectOp("R9", S_START, 32'h0020);
    expectOp("R9", S_RV, 0);
    fire();
    cfg(1'b1, 1'b0, 2'd0, 16'h0020);
    setBase(4'd5);
    writeReg(4'd0, 32'h8000_0010);
    retw(32'h9000_0004);
    expectOp("R9", S_CODE, 7);
    expectOp("R9", S_BASE, 3);
    fire();
    cfg(1'b1, 1'b0, 2'd0, 16'h0020);
    setBase(4'd5);
    writeReg(4'd0, 32'hC000_0010);
    retw(32'h9000_0008);
    expectOp("R9", S_CODE, 8);
    expectOp("R9", S_BASE, 2);
    fire();

    // R7 illegal returns
    cfg(1'b1, 1'b0, 2'd0, 16'h0020);
    setBase(4'd5);
    writeReg(4'd0, 32'h0000_0010);
    retw(32'h0);
    expectOp("R7", S_CODE, 1);
    expectOp("R7", S_BASE, 5);
    fire();
    cfg(1'b1, 1'b0, 2'd0, 16'h0006);
    setBase(4'd2);
    writeReg(4'd0, 32'h8000_0000);
    retw(32'h0);
    expectOp("R7", S_CODE, 1);
    expectOp("R7", S_BASE, 2);
    fire();
    cfg(1'b1, 1'b1, 2'd0, 16'h0005);
    retw(32'h0);
    expectOp("R7", S_CODE, 1);
    expectOp("R7", S_START, 32'h0005);
    fire();

    // R10 stack-pointer move check
    cfg(1'b1, 1'b0, 2'd0, 16'h0010);
    setBase(4'd4);
    setOp(3'd5);
    expectOp("R10", S_CODE, 2);
    expectOp("R10", S_BASE, 4);
    fire();
    cfg(1'b1, 1'b0, 2'd0, 16'h0014);
    setOp(3'd5);
    expectOp("R10", S_EV, 0);
    fire();

    // R11 signed rotate with wrap
    setBase(4'd1);
    setOp(3'd2); opRot = 4'hD;
    expectOp("R11", S_BASE, 14);
    fire();
    setOp(3'd2); opRot = 4'h7;
    expectOp("R11", S_BASE, 5);
    fire();

    step();
    step();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule